// File: doc/BRIEF.md
# Three-Space DSP Memory Decoder

This block decodes the memory accesses of a 24-bit fixed-point signal processor that has two data spaces (X and Y) and one program space (P). Every access carries a 16-bit address and a space selector. The decoder sends the access to one of four storage targets: an internal RAM that each space owns, a small internal data ROM in X and Y, a bank of 64 peripheral registers in X and Y, or one external RAM that all three spaces share. A read returns its 24-bit word, and a code that names the region that served it, on the clock cycle after the strobe.

The X and Y external regions fold onto the shared external array. Each data space sees half of it, X the upper half and Y the lower half. The program space sees the whole array, so a program word can be reached through X or Y as well. A mode input turns the data ROM on or off. When the ROM is off, its address window falls through to the external mapping. Writes use the same mapping as reads, except that a write which decodes to the ROM is dropped. All storage lives in plain register arrays inside the block. `EXT_WORDS` sets the external array size; its default is small so that the block elaborates quickly, and the target build sets it to 32768.

Top module: `dsp_mem_decoder`

## Requirements
- R1: During reset and after it, `rdValid`, `rdData` and `rdRegion` are all 0 until the first read.
- R2: `rdValid` is high exactly in the cycle after each cycle with `rdEn` high. Reads may be issued back to back, one per cycle.
- R3: In any space, an address below 0x100 reads that space's own internal RAM with region code 0. In P space, the internal RAM reaches up to 0x1FF. X, Y and P internal RAMs are separate.
- R4: With `romEnable` = 1, an X or Y address from 0x100 to 0x1FF reads the ROM with region code 1. The word is the 16-bit address XOR 0xA50000 in X, and XOR 0x5A0000 in Y.
- R5: With `romEnable` = 0, X or Y addresses from 0x100 to 0x1FF use the external mapping of R7 with region code 2.
- R6: In X or Y, an address of 0xFFC0 or above reads peripheral register (address − 0xFFC0) of that space with region code 3. X and Y banks are separate.
- R7: Region code 2 marks the external RAM. The external index is: for P at or above 0x200, the address modulo `EXT_WORDS`; for Y, the address modulo `EXT_WORDS`/2; for X, the address modulo `EXT_WORDS`/2 plus `EXT_WORDS`/2. All three spaces share one array.
- R8: A write that decodes to the ROM changes nothing. The ROM word still reads back, and the external word at the same X/Y address keeps its value.
- R9: Space codes are 0 = X, 1 = Y, 2 = P. Code 3 behaves exactly as X for reads and writes.
- R10: While `rdEn` stays low, `rdData` and `rdRegion` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| space | input | 2 | Space selector: 0 X, 1 Y, 2 P, 3 treated as X |
| addr | input | 16 | Word address |
| wrData | input | 24 | Write data |
| romEnable | input | 1 | Data ROM enable mode bit |
| rdData | output | 24 | Read data, one cycle after the strobe |
| rdValid | output | 1 | Read data valid |
| rdRegion | output | 2 | Region code: 0 internal RAM, 1 ROM, 2 external, 3 peripheral |

## Verification
Distinct values are written to the same low address in X, Y and P, and then read back. This shows whether the three internal RAMs are kept apart. The ROM window is read with the mode bit set and with it clear, and it is written while the mode bit is set; this separates ROM decode, fall-through and dropped writes. External words are written through one space and read through another, at addresses that alias: X 0x200 against P 0x200, Y 0x300 against P 0x500, and X 0x4000 against X 0x200. This exposes mistakes in the half-array fold and in the masking. Peripheral words at both ends of the bank, and accesses with space code 3, check the index offset and the fallback to X.

// File: rtl/dsp_mem_pkg.sv
package dsp_mem_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 24;

  typedef enum logic [1:0] {
    REGION_IRAM = 2'd0,
    REGION_ROM  = 2'd1,
    REGION_EXT  = 2'd2,
    REGION_PERI = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    SPACE_X = 2'd0,
    SPACE_Y = 2'd1,
    SPACE_P = 2'd2
  } space_e;

  // strobes and decoded location handed from control to datapath
  typedef struct packed {
    logic              rdStrobe;
    logic              wrStrobe;
    region_e           region;
    space_e            spaceSel;
    logic [ADDR_W-1:0] index;
  } mem_ctrl_t;

endpackage

// File: rtl/dsp_mem_decode_ctrl.sv
module dsp_mem_decode_ctrl
  import dsp_mem_pkg::*;
#(
  parameter int EXT_WORDS   = 1024,
  parameter int IRAM_TOP    = 'h100,
  parameter int PRAM_TOP    = 'h200,
  parameter int ROM_TOP     = 'h200,
  parameter int PERI_BASE   = 'hFFC0
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [1:0]        space,
  input  logic [ADDR_W-1:0] addr,
  input  logic              romEnable,
  output mem_ctrl_t         ctrl
);

  localparam int HALF_WORDS = EXT_WORDS / 2;
  localparam logic [ADDR_W-1:0] EXT_MASK  = ADDR_W'(EXT_WORDS - 1);
  localparam logic [ADDR_W-1:0] HALF_MASK = ADDR_W'(HALF_WORDS - 1);
  localparam logic [ADDR_W-1:0] HALF_OFS  = ADDR_W'(HALF_WORDS);

  space_e  spaceSel;
  region_e region;
  logic [ADDR_W-1:0] index;
  logic [ADDR_W-1:0] dataExtIdx;

  always_comb begin
    case (space)
      2'd1:    spaceSel = SPACE_Y;
      2'd2:    spaceSel = SPACE_P;
      default: spaceSel = SPACE_X;
    endcase
  end

  // fold of X/Y onto the shared array: Y low half, X high half
  always_comb begin
    dataExtIdx = addr & HALF_MASK;
    if (spaceSel == SPACE_X) dataExtIdx = dataExtIdx + HALF_OFS;
  end

  always_comb begin
    region = REGION_EXT;
    index  = dataExtIdx;
    if (addr < ADDR_W'(IRAM_TOP)) begin
      region = REGION_IRAM;
      index  = addr;
    end else if (spaceSel == SPACE_P) begin
      if (addr < ADDR_W'(PRAM_TOP)) begin
        region = REGION_IRAM;
        index  = addr;
      end else begin
        region = REGION_EXT;
        index  = addr & EXT_MASK;
      end
    end else if (romEnable && addr < ADDR_W'(ROM_TOP)) begin
      region = REGION_ROM;
      index  = addr - ADDR_W'(IRAM_TOP);
    end else if (addr >= ADDR_W'(PERI_BASE)) begin
      region = REGION_PERI;
      index  = addr - ADDR_W'(PERI_BASE);
    end
  end

  always_comb begin
    ctrl.rdStrobe = rdEn;
    ctrl.wrStrobe = wrEn && (region != REGION_ROM);
    ctrl.region   = region;
    ctrl.spaceSel = spaceSel;
    ctrl.index    = index;
  end

endmodule

// File: rtl/dsp_mem_datapath.sv
module dsp_mem_datapath
  import dsp_mem_pkg::*;
#(
  parameter int EXT_WORDS  = 1024,
  parameter int XY_RAM     = 256,
  parameter int P_RAM      = 512,
  parameter int PERI_REGS  = 64,
  parameter int ROM_BASE   = 'h100,
  parameter logic [DATA_W-1:0] ROM_KEY_X = 24'hA50000,
  parameter logic [DATA_W-1:0] ROM_KEY_Y = 24'h5A0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  mem_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [1:0]        rdRegion
);

  localparam int EXT_AW  = $clog2(EXT_WORDS);
  localparam int XY_AW   = $clog2(XY_RAM);
  localparam int P_AW    = $clog2(P_RAM);
  localparam int PERI_AW = $clog2(PERI_REGS);
  localparam int NUM_DATA_SPACES = 2;

  logic [DATA_W-1:0] ramX [XY_RAM];
  logic [DATA_W-1:0] ramY [XY_RAM];
  logic [DATA_W-1:0] ramP [P_RAM];
  logic [DATA_W-1:0] extRam [EXT_WORDS];
  logic [DATA_W-1:0] periRd [NUM_DATA_SPACES];

  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] romWord;
  logic              isY;

  assign isY = (ctrl.spaceSel == SPACE_Y);

  // fixed ROM pattern: absolute address XOR a per-space key
  assign romWord = (DATA_W'(ROM_BASE) + DATA_W'(ctrl.index)) ^ (isY ? ROM_KEY_Y : ROM_KEY_X);

  // one peripheral bank per data space
  for (genvar s = 0; s < NUM_DATA_SPACES; s++) begin : g_peri
    logic [DATA_W-1:0] periBank [PERI_REGS];
    logic bankSel;
    assign bankSel = (s == 1) ? isY : !isY;
    always_ff @(posedge clk) begin
      if (ctrl.wrStrobe && ctrl.region == REGION_PERI && ctrl.spaceSel != SPACE_P && bankSel)
        periBank[ctrl.index[PERI_AW-1:0]] <= wrData;
    end
    assign periRd[s] = periBank[ctrl.index[PERI_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (ctrl.wrStrobe) begin
      case (ctrl.region)
        REGION_IRAM: begin
          case (ctrl.spaceSel)
            SPACE_Y: ramY[ctrl.index[XY_AW-1:0]] <= wrData;
            SPACE_P: ramP[ctrl.index[P_AW-1:0]]  <= wrData;
            default: ramX[ctrl.index[XY_AW-1:0]] <= wrData;
          endcase
        end
        REGION_EXT: extRam[ctrl.index[EXT_AW-1:0]] <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ctrl.region)
      REGION_IRAM: begin
        case (ctrl.spaceSel)
          SPACE_Y: readWord = ramY[ctrl.index[XY_AW-1:0]];
          SPACE_P: readWord = ramP[ctrl.index[P_AW-1:0]];
          default: readWord = ramX[ctrl.index[XY_AW-1:0]];
        endcase
      end
      REGION_ROM:  readWord = romWord;
      REGION_EXT:  readWord = extRam[ctrl.index[EXT_AW-1:0]];
      default:     readWord = isY ? periRd[1] : periRd[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdData   <= '0;
      rdRegion <= 2'd0;
    end else begin
      rdValid <= ctrl.rdStrobe;
      if (ctrl.rdStrobe) begin
        rdData   <= readWord;
        rdRegion <= ctrl.region;
      end
    end
  end

endmodule

// File: rtl/dsp_mem_decoder.sv
module dsp_mem_decoder
  import dsp_mem_pkg::*;
#(
  parameter int EXT_WORDS = 1024,
  parameter logic [23:0] ROM_KEY_X = 24'hA50000,
  parameter logic [23:0] ROM_KEY_Y = 24'h5A0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [1:0]  space,
  input  logic [15:0] addr,
  input  logic [23:0] wrData,
  input  logic        romEnable,
  output logic [23:0] rdData,
  output logic        rdValid,
  output logic [1:0]  rdRegion
);

  mem_ctrl_t ctrl;

  dsp_mem_decode_ctrl #(.EXT_WORDS(EXT_WORDS)) ctrl_i (
    .rdEn(rdEn), .wrEn(wrEn), .space(space), .addr(addr),
    .romEnable(romEnable), .ctrl(ctrl)
  );

  dsp_mem_datapath #(
    .EXT_WORDS(EXT_WORDS), .ROM_KEY_X(ROM_KEY_X), .ROM_KEY_Y(ROM_KEY_Y)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .rdRegion(rdRegion)
  );

endmodule

// File: rtl/dsp_mem_decoder_chk.sv
module dsp_mem_decoder_chk #(
  parameter logic [23:0] ROM_KEY_X = 24'hA50000,
  parameter logic [23:0] ROM_KEY_Y = 24'h5A0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic [1:0]  space,
  input logic [15:0] addr,
  input logic        romEnable,
  input logic [23:0] rdData,
  input logic        rdValid,
  input logic [1:0]  rdRegion
);

  logic isData;
  assign isData = (space != 2'd2);

  assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
  assert_low_ram_region_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr < 16'h0100) |=> rdRegion == 2'd0);
  assert_rom_region_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && romEnable && isData && addr[15:8] == 8'h01) |=> rdRegion == 2'd1);
  assert_rom_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && romEnable && isData && addr[15:8] == 8'h01) |=>
      rdData == ({8'h00, $past(addr)} ^ (($past(space) == 2'd1) ? ROM_KEY_Y : ROM_KEY_X)));
  assert_rom_off_ext_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !romEnable && isData && addr[15:8] == 8'h01) |=> rdRegion == 2'd2);
  assert_peri_region_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isData && addr >= 16'hFFC0) |=> rdRegion == 2'd3);
  assert_p_ext_region_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !isData && addr >= 16'h0200) |=> rdRegion == 2'd2);
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> ($stable(rdData) && $stable(rdRegion)));

endmodule

bind dsp_mem_decoder dsp_mem_decoder_chk #(.ROM_KEY_X(ROM_KEY_X), .ROM_KEY_Y(ROM_KEY_Y)) chk_i (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .space(space), .addr(addr),
  .romEnable(romEnable), .rdData(rdData), .rdValid(rdValid), .rdRegion(rdRegion)
);

// File: tb/dsp_mem_decoder_tb_top.sv
module dsp_mem_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  space = 2'd0;
  logic [15:0] addr = '0;
  logic [23:0] wrData = '0;
  logic        romEnable = 1'b0;
  logic [23:0] rdData;
  logic        rdValid;
  logic [1:0]  rdRegion;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [23:0] expD[$];
  logic [1:0]  expR[$];
  string       expTag[$];

  always #4 clk = ~clk;

  dsp_mem_decoder dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .space(space),
    .addr(addr), .wrData(wrData), .romEnable(romEnable),
    .rdData(rdData), .rdValid(rdValid), .rdRegion(rdRegion)
  );

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic rdOp(input logic [1:0] sp, input logic [15:0] a, input logic rom,
                      input logic [23:0] ed, input logic [1:0] er, input string tag);
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b0; space = sp; addr = a; romEnable = rom;
    expD.push_back(ed); expR.push_back(er); expTag.push_back(tag);
  endtask

  task automatic wrOp(input logic [1:0] sp, input logic [15:0] a, input logic rom, input logic [23:0] d);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b1; space = sp; addr = a; romEnable = rom; wrData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdEn = 1'b0; wrEn = 1'b0;
    end
  endtask

  // monitor: pops expected items as reads complete
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rdValid) begin
        if (expD.size() == 0) begin
          check(1'b0, "R2 unexpected rdValid", {23'd0, rdValid}, 24'd0);
        end else begin
          logic [23:0] d;
          logic [1:0]  r;
          string t;
          d = expD.pop_front(); r = expR.pop_front(); t = expTag.pop_front();
          check(rdData == d, {t, " data"}, rdData, d);
          check(rdRegion == r, {t, " region"}, {22'd0, rdRegion}, {22'd0, r});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdValid == 1'b0, "R1 rdValid in reset", {23'd0, rdValid}, 24'd0);
    check(rdData == 24'd0, "R1 rdData in reset", rdData, 24'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(rdValid == 1'b0 && rdRegion == 2'd0, "R1 after reset", {22'd0, rdRegion}, 24'd0);

    // R3 internal RAMs per space
    wrOp(2'd0, 16'h0010, 1'b0, 24'h111111);
    wrOp(2'd1, 16'h0010, 1'b0, 24'h222222);
    wrOp(2'd2, 16'h0010, 1'b0, 24'h333333);
    wrOp(2'd2, 16'h01F0, 1'b0, 24'h444444);
    rdOp(2'd0, 16'h0010, 1'b0, 24'h111111, 2'd0, "R3 X iram");
    rdOp(2'd1, 16'h0010, 1'b0, 24'h222222, 2'd0, "R3 Y iram");
    rdOp(2'd2, 16'h0010, 1'b0, 24'h333333, 2'd0, "R3 P iram");
    rdOp(2'd2, 16'h01F0, 1'b1, 24'h444444, 2'd0, "R3 P iram upper");

    // R4 ROM, R5 fall-through, R8 ignored ROM writes
    wrOp(2'd0, 16'h0123, 1'b0, 24'h0BEEF0);
    rdOp(2'd0, 16'h0123, 1'b1, 24'hA50123, 2'd1, "R4 X rom");
    rdOp(2'd1, 16'h01FF, 1'b1, 24'h5A01FF, 2'd1, "R4 Y rom");
    wrOp(2'd0, 16'h0123, 1'b1, 24'hDEAD00);
    rdOp(2'd0, 16'h0123, 1'b1, 24'hA50123, 2'd1, "R8 rom unchanged");
    rdOp(2'd0, 16'h0123, 1'b0, 24'h0BEEF0, 2'd2, "R8 R5 ext kept under rom");
    rdOp(2'd2, 16'h0323, 1'b0, 24'h0BEEF0, 2'd2, "R5 P view of X fallthrough");

    // R6 peripheral banks
    wrOp(2'd0, 16'hFFC0, 1'b0, 24'h0A0A0A);
    wrOp(2'd1, 16'hFFFF, 1'b0, 24'h0B0B0B);
    wrOp(2'd1, 16'hFFC0, 1'b0, 24'h0C0C0C);
    rdOp(2'd0, 16'hFFC0, 1'b0, 24'h0A0A0A, 2'd3, "R6 X peri 0");
    rdOp(2'd1, 16'hFFFF, 1'b0, 24'h0B0B0B, 2'd3, "R6 Y peri 63");
    rdOp(2'd1, 16'hFFC0, 1'b0, 24'h0C0C0C, 2'd3, "R6 Y peri 0");

    // R7 external fold and sharing
    wrOp(2'd0, 16'h0200, 1'b0, 24'h777001);
    rdOp(2'd2, 16'h0200, 1'b0, 24'h777001, 2'd2, "R7 X upper half via P");
    wrOp(2'd1, 16'h0300, 1'b0, 24'h777002);
    rdOp(2'd2, 16'h0500, 1'b0, 24'h777002, 2'd2, "R7 Y lower half via P");
    wrOp(2'd0, 16'h4000, 1'b0, 24'h777003);
    rdOp(2'd0, 16'h0200, 1'b0, 24'h777003, 2'd2, "R7 X alias mask");
    wrOp(2'd2, 16'h03FF, 1'b0, 24'h777004);
    rdOp(2'd0, 16'h03FF, 1'b0, 24'h777004, 2'd2, "R7 P write X read");

    // R9 space code 3 acts as X
    rdOp(2'd3, 16'h0010, 1'b0, 24'h111111, 2'd0, "R9 space3 iram");
    wrOp(2'd3, 16'hFFC1, 1'b0, 24'h0D0D0D);
    rdOp(2'd0, 16'hFFC1, 1'b0, 24'h0D0D0D, 2'd3, "R9 space3 peri write");
    rdOp(2'd3, 16'h0150, 1'b1, 24'hA50150, 2'd1, "R9 space3 rom");

    // R10 hold while idle, R2 no valid while idle
    idle(4);
    check(rdValid == 1'b0, "R2 idle valid low", {23'd0, rdValid}, 24'd0);
    check(rdData == 24'hA50150, "R10 data held", rdData, 24'hA50150);
    check(rdRegion == 2'd1, "R10 region held", {22'd0, rdRegion}, 24'd1);
    check(expD.size() == 0, "R2 all reads returned", 24'(expD.size()), 24'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule